// File: doc/BRIEF.md
# Multichannel Acquisition Scan Sequencer

This block decides when an external converter is started and which analog input it samples. Software arms an acquisition, which loads a sample down-counter and raises an acquire flag. While that flag is high, triggers arrive either from an internal interval timer or from the falling edge of an external digital input. Each trigger starts a frame. A frame holds one sample, one scan, or a chosen number of back-to-back scans. Within a scan the channel address walks upward from channel 0 to a programmed last channel. In multi-scan frames it then wraps back to 0.

Every new address is held for a programmable number of settle clocks before a one-cycle start pulse goes out. The converter's end-of-conversion strobe decrements the sample counter. A pacing timer then spaces the next sample of the frame. When the counter expires the acquire flag drops and no further frames run.

The channel can be chosen three ways: a fixed channel, sequential advance, or an address written by the host. In differential mode only the lower half of the address range is used. Both timers count either every clock or only on pulses of an external timebase strobe.

Top module: `scan_sequencer`

## Requirements
- R1: After reset `acquire`, `adc_start` and `ch_addr` are all 0.
- R2: A pulse on `arm` sets `acquire` and loads `cfg_samples`, which holds the sample count minus one. `acquire` clears on the EOC that completes the last sample. While `acquire` is 0 no start pulse is issued.
- R3: With `cfg_addr_mode` = 1 (sequential), samples use addresses 0,1,…,last in order. After the last channel the address wraps to 0, so a multi-scan frame repeats the list.
- R4: With `cfg_diff` = 1 the address never exceeds 7. A last channel above 7 is clamped to 7, and fixed or host addresses keep only their low three bits.
- R5: With `cfg_addr_mode` = 0 (fixed) every sample uses `cfg_fix_ch`. Each scan is one sample.
- R6: With `cfg_addr_mode` = 2 (host) every sample uses the address written through `host_ch_wr`/`host_ch` while no frame runs. Each scan is one sample.
- R7: `cfg_trig_mode` selects what a trigger starts. 0 starts one sample; in sequential mode the next trigger continues at the next channel. 1 starts one scan. 2 starts `cfg_scan_count` contiguous scans.
- R8: With `cfg_trig_ext` = 1 a frame starts on a falling edge of `ext_trig_n`. That input passes two synchronizer flops. The start pulse is visible on the 4+`cfg_settle`-th falling clock edge after the input falls. A rising edge does nothing.
- R9: With `cfg_trig_ext` = 0, triggers come from the interval timer every `cfg_scan_div`+1 timebase cycles after arming.
- R10: Within a frame, the next start comes `cfg_start_div`+`cfg_settle`+2 cycles after the cycle in which EOC is sampled high. `adc_start` is always a single-cycle pulse.
- R11: `ch_addr` is unchanged for at least `cfg_settle`+1 cycles when a start is issued.
- R12: A trigger that arrives while a frame is in progress is ignored.
- R13: With `cfg_tb_ext` = 1 the pacing and interval timers advance only in cycles where `tb_pulse` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_addr_mode | input | 2 | 0 fixed, 1 sequential, 2 or 3 host address |
| cfg_diff | input | 1 | 1 selects differential (8-channel) addressing |
| cfg_last_ch | input | CH_W | Last channel of a sequential scan |
| cfg_fix_ch | input | CH_W | Channel used in fixed mode |
| host_ch_wr | input | 1 | Host address write strobe |
| host_ch | input | CH_W | Host-written channel address |
| cfg_trig_mode | input | 2 | 0 one sample, 1 one scan, 2 or 3 multi-scan |
| cfg_scan_count | input | SCAN_W | Scans per frame in multi-scan mode (0 acts as 1) |
| cfg_trig_ext | input | 1 | 1 external trigger, 0 internal interval timer |
| ext_trig_n | input | 1 | Asynchronous external trigger, falling edge active |
| cfg_tb_ext | input | 1 | 1 timers step on `tb_pulse` only |
| tb_pulse | input | 1 | Synchronous external timebase strobe |
| cfg_start_div | input | TMR_W | Pacing divisor between samples of a frame |
| cfg_scan_div | input | TMR_W | Interval timer divisor between triggers |
| cfg_settle | input | SETTLE_W | Settle clocks before each start |
| cfg_samples | input | CNT_W | Samples per acquisition minus one |
| arm | input | 1 | Starts an acquisition |
| adc_eoc | input | 1 | Converter end-of-conversion strobe |
| ch_addr | output | CH_W | Channel address to the input multiplexer |
| adc_start | output | 1 | One-cycle conversion start |
| acquire | output | 1 | Acquisition in progress |

## Verification
For a trigger the start pulse is due a fixed count of clocks later. On the external path that count is two synchronizer flops, one capture cycle and the settle count. On the internal path it is the divisor plus one per trigger. For later samples in a frame it is the responder's EOC delay plus pacing plus settle. The bench counts falling clock edges from each stimulus and compares the count with these sums. It also timestamps every start in the monitor and compares successive gaps with the formula. Channel order is checked by a scoreboard queue filled before each trigger. Every start pops one entry, so a start that should be ignored shows up as an unexpected pop or a non-empty queue after the drain window.

// File: rtl/scan_sequencer.sv
module scan_sequencer #(
  parameter int CH_W     = 4,
  parameter int TMR_W    = 16,
  parameter int CNT_W    = 16,
  parameter int SETTLE_W = 8,
  parameter int SCAN_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_addr_mode,
  input  logic                cfg_diff,
  input  logic [CH_W-1:0]     cfg_last_ch,
  input  logic [CH_W-1:0]     cfg_fix_ch,
  input  logic                host_ch_wr,
  input  logic [CH_W-1:0]     host_ch,
  input  logic [1:0]          cfg_trig_mode,
  input  logic [SCAN_W-1:0]   cfg_scan_count,
  input  logic                cfg_trig_ext,
  input  logic                ext_trig_n,
  input  logic                cfg_tb_ext,
  input  logic                tb_pulse,
  input  logic [TMR_W-1:0]    cfg_start_div,
  input  logic [TMR_W-1:0]    cfg_scan_div,
  input  logic [SETTLE_W-1:0] cfg_settle,
  input  logic [CNT_W-1:0]    cfg_samples,
  input  logic                arm,
  input  logic                adc_eoc,
  output logic [CH_W-1:0]     ch_addr,
  output logic                adc_start,
  output logic                acquire
);
  localparam logic [CH_W-1:0] FULL_MAX = CH_W'((1 << CH_W) - 1);
  localparam logic [CH_W-1:0] DIFF_MAX = CH_W'((1 << (CH_W - 1)) - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_PACE, ST_SETTLE, ST_CONV} st_t;
  st_t state;

  logic [TMR_W-1:0]  cnt, scan_tmr;
  logic [CNT_W-1:0]  samp_left;
  logic [SCAN_W-1:0] scans_left;
  logic [2:0]        ext_sync;

  wire tick      = cfg_tb_ext ? tb_pulse : 1'b1;
  wire ext_fall  = ext_sync[2] & ~ext_sync[1];
  wire int_fire  = acquire & tick & (scan_tmr == '0);
  wire trig      = acquire & ~arm & (cfg_trig_ext ? ext_fall : int_fire);
  wire seq_mode  = (cfg_addr_mode == 2'd1);
  wire [CH_W-1:0] ch_mask  = cfg_diff ? DIFF_MAX : FULL_MAX;
  wire [CH_W-1:0] eff_last = (cfg_diff && cfg_last_ch > DIFF_MAX) ? DIFF_MAX : cfg_last_ch;
  wire scan_end  = seq_mode ? (ch_addr >= eff_last) : 1'b1;
  wire frame_end = (cfg_trig_mode == 2'd0) || (scan_end && scans_left <= SCAN_W'(1));
  wire [CH_W-1:0] ch_next = seq_mode ? (scan_end ? '0 : ch_addr + CH_W'(1)) : ch_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_sync <= '1;
    else        ext_sync <= {ext_sync[1:0], ext_trig_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                scan_tmr <= '0;
    else if (arm)              scan_tmr <= cfg_scan_div;
    else if (acquire && tick)  scan_tmr <= (scan_tmr == '0) ? cfg_scan_div : scan_tmr - TMR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      ch_addr    <= '0;
      acquire    <= 1'b0;
      adc_start  <= 1'b0;
      cnt        <= '0;
      samp_left  <= '0;
      scans_left <= '0;
    end else begin
      adc_start <= 1'b0;
      if (arm) begin
        acquire   <= 1'b1;
        samp_left <= cfg_samples;
        state     <= ST_IDLE;
        ch_addr   <= '0;
      end else begin
        if (host_ch_wr && state == ST_IDLE && cfg_addr_mode[1])
          ch_addr <= host_ch & ch_mask;
        case (state)
          ST_IDLE:
            if (trig) begin
              state      <= ST_SETTLE;
              cnt        <= TMR_W'(cfg_settle);
              scans_left <= (cfg_trig_mode[1] && cfg_scan_count != '0) ? cfg_scan_count : SCAN_W'(1);
              if (cfg_addr_mode == 2'd0) ch_addr <= cfg_fix_ch & ch_mask;
            end
          ST_SETTLE:
            if (cnt == '0) begin
              adc_start <= 1'b1;
              state     <= ST_CONV;
            end else cnt <= cnt - TMR_W'(1);
          ST_CONV:
            if (adc_eoc) begin
              ch_addr <= ch_next;
              if (samp_left == '0) begin
                acquire <= 1'b0;
                state   <= ST_IDLE;
              end else begin
                samp_left <= samp_left - CNT_W'(1);
                if (frame_end) state <= ST_IDLE;
                else begin
                  if (scan_end) scans_left <= scans_left - SCAN_W'(1);
                  state <= ST_PACE;
                  cnt   <= cfg_start_div;
                end
              end
            end
          ST_PACE:
            if (tick) begin
              if (cnt == '0) begin
                state <= ST_SETTLE;
                cnt   <= TMR_W'(cfg_settle);
              end else cnt <= cnt - TMR_W'(1);
            end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/scan_sequencer_chk.sv
module scan_sequencer_chk #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      cfg_addr_mode,
  input logic            cfg_diff,
  input logic [CH_W-1:0] cfg_last_ch,
  input logic            adc_eoc,
  input logic [CH_W-1:0] ch_addr,
  input logic            adc_start,
  input logic            acquire
);
  localparam int DIFF_N = 1 << (CH_W - 1);

  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acquire |-> !adc_start); // R2
  AST_ACQ_ENDS_ON_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acquire) |-> $past(adc_eoc)); // R2
  AST_SEQ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && cfg_addr_mode == 2'd1 && !cfg_diff) |-> ch_addr <= cfg_last_ch); // R3
  AST_DIFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start && cfg_diff) |-> int'(ch_addr) < DIFF_N); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start); // R10
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> $stable(ch_addr)); // R11
endmodule

bind scan_sequencer scan_sequencer_chk #(.CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_addr_mode(cfg_addr_mode), .cfg_diff(cfg_diff),
  .cfg_last_ch(cfg_last_ch), .adc_eoc(adc_eoc), .ch_addr(ch_addr),
  .adc_start(adc_start), .acquire(acquire)
);

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int EOC_LAT    = 3;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_addr_mode = 1;
  logic cfg_diff = 0;
  logic [3:0] cfg_last_ch = 3, cfg_fix_ch = 0, host_ch = 0;
  logic host_ch_wr = 0;
  logic [1:0] cfg_trig_mode = 1;
  logic [7:0] cfg_scan_count = 1;
  logic cfg_trig_ext = 1, ext_trig_n = 1, cfg_tb_ext = 0, tb_pulse = 0;
  logic [15:0] cfg_start_div = 1, cfg_scan_div = 39, cfg_samples = 1000;
  logic [7:0] cfg_settle = 2;
  logic arm = 0, adc_eoc = 0;
  logic [3:0] ch_addr;
  logic adc_start, acquire;

  int nchk = 0, nerr = 0, nstarts = 0, cyc = 0, last_start = 0, stab = 0;
  bit have_prev = 0;
  logic [3:0] prev_ch = 0;
  int exp_q[$];
  int gaps[$];
  string cur_req = "R3";

  scan_sequencer dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  // monitor: scoreboard pop, gap timing, settle stability
  always @(negedge clk) begin
    cyc++;
    if (ch_addr != prev_ch) stab = 0; else stab++;
    prev_ch = ch_addr;
    if (rst_n && adc_start) begin
      nstarts++;
      if (have_prev) gaps.push_back(cyc - last_start);
      last_start = cyc;
      have_prev = 1;
      chk(stab >= int'(cfg_settle) + 1, "R11", stab, int'(cfg_settle) + 1);
      if (exp_q.size() == 0) chk(0, {cur_req, " unexpected start"}, ch_addr, -1);
      else begin
        automatic int e = exp_q.pop_front();
        chk(int'(ch_addr) == e, cur_req, ch_addr, e);
      end
    end
  end

  // converter model
  initial forever begin
    @(negedge clk);
    if (rst_n && adc_start) begin
      repeat (EOC_LAT) @(negedge clk);
      adc_eoc = 1;
      @(negedge clk);
      adc_eoc = 0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic clr();
    gaps.delete(); have_prev = 0; nstarts = 0;
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1;
    @(negedge clk) arm = 0;
  endtask

  task automatic ext_pulse();
    @(negedge clk) ext_trig_n = 0;
    repeat (3) @(negedge clk);
    ext_trig_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drain(input string rq);
    for (int i = 0; i < 800 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 0, rq, exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(acquire == 0, "R1", acquire, 0);
    chk(adc_start == 0, "R1", adc_start, 0);
    chk(ch_addr == 0, "R1", ch_addr, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R8 latency, R3 order, R10 pacing
    cur_req = "R3"; clr();
    do_arm();
    chk(acquire == 1, "R2", acquire, 1);
    for (int c = 0; c <= 3; c++) exp_q.push_back(c);
    @(negedge clk) ext_trig_n = 0;
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!adc_start && n < 50);
      chk(n == int'(cfg_settle) + 4, "R8", n, int'(cfg_settle) + 4);
    end
    ext_trig_n = 1;
    drain("R3");
    chk(gaps.size() == 3, "R10", gaps.size(), 3);
    foreach (gaps[i])
      chk(gaps[i] == EOC_LAT + int'(cfg_start_div) + int'(cfg_settle) + 3, "R10",
          gaps[i], EOC_LAT + int'(cfg_start_div) + int'(cfg_settle) + 3);
    chk(acquire == 1, "R2", acquire, 1);

    // R7 multi-scan wrap
    cur_req = "R7"; clr();
    cfg_trig_mode = 2; cfg_scan_count = 3; cfg_last_ch = 2;
    do_arm();
    for (int s = 0; s < 3; s++) for (int c = 0; c <= 2; c++) exp_q.push_back(c);
    ext_pulse();
    drain("R7");

    // R2 sample counter ends acquisition mid-frame
    cur_req = "R2"; clr();
    cfg_samples = 4;
    do_arm();
    foreach (exp_q[i]) ;
    exp_q = '{0, 1, 2, 0, 1};
    ext_pulse();
    drain("R2");
    chk(acquire == 0, "R2", acquire, 0);
    ext_pulse();
    repeat (40) @(negedge clk);
    chk(nstarts == 5, "R2", nstarts, 5);

    // R4 differential clamp
    cur_req = "R4"; clr();
    cfg_samples = 1000; cfg_diff = 1; cfg_last_ch = 12; cfg_trig_mode = 1;
    do_arm();
    for (int c = 0; c <= 7; c++) exp_q.push_back(c);
    ext_pulse();
    drain("R4");

    // R5 fixed channel, masked in differential mode
    cur_req = "R5"; clr();
    cfg_diff = 0; cfg_addr_mode = 0; cfg_fix_ch = 9; cfg_trig_mode = 0;
    do_arm();
    exp_q = '{9};
    ext_pulse();
    drain("R5");
    exp_q = '{9};
    ext_pulse();
    drain("R5");
    cur_req = "R4"; cfg_diff = 1; cfg_fix_ch = 13;
    exp_q = '{5};
    ext_pulse();
    drain("R4");

    // R6 host address
    cur_req = "R6"; clr();
    cfg_diff = 0; cfg_addr_mode = 2; cfg_trig_mode = 1;
    do_arm();
    @(negedge clk) begin host_ch_wr = 1; host_ch = 6; end
    @(negedge clk) host_ch_wr = 0;
    exp_q = '{6};
    ext_pulse();
    drain("R6");

    // R7 single sample per trigger in sequential mode
    cur_req = "R7"; clr();
    cfg_addr_mode = 1; cfg_last_ch = 3; cfg_trig_mode = 0;
    do_arm();
    exp_q = '{0};
    ext_pulse();
    drain("R7");
    exp_q = '{1};
    ext_pulse();
    drain("R7");

    // R12 trigger during frame ignored
    cur_req = "R12"; clr();
    cfg_trig_mode = 1; cfg_start_div = 10;
    do_arm();
    exp_q = '{0, 1, 2, 3};
    ext_pulse();
    while (nstarts < 1) @(negedge clk);
    ext_pulse();
    drain("R12");
    chk(nstarts == 4, "R12", nstarts, 4);

    // R9 internal interval timer
    cur_req = "R9"; clr();
    cfg_trig_ext = 0; cfg_scan_div = 39; cfg_trig_mode = 0; cfg_last_ch = 7;
    cfg_samples = 3; cfg_start_div = 1;
    do_arm();
    exp_q = '{0, 1, 2, 3};
    drain("R9");
    chk(gaps.size() == 3, "R9", gaps.size(), 3);
    foreach (gaps[i]) chk(gaps[i] == int'(cfg_scan_div) + 1, "R9", gaps[i], int'(cfg_scan_div) + 1);
    chk(acquire == 0, "R2", acquire, 0);

    // R13 external timebase gates pacing
    cur_req = "R13"; clr();
    cfg_trig_ext = 1; cfg_tb_ext = 1; cfg_trig_mode = 1; cfg_last_ch = 1;
    cfg_start_div = 2; cfg_settle = 0; cfg_samples = 1000;
    do_arm();
    exp_q = '{0, 1};
    ext_pulse();
    repeat (30) @(negedge clk);
    chk(nstarts == 1, "R13", nstarts, 1);
    for (int p = 0; p < 3; p++) begin
      @(negedge clk) tb_pulse = 1;
      @(negedge clk) tb_pulse = 0;
      repeat (2) @(negedge clk);
    end
    drain("R13");
    chk(nstarts == 2, "R13", nstarts, 2);

    finish_run();
  end
endmodule